// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Link

This block sits at the bottom of a slave on an open-drain single-wire bus. It watches the already-synchronised line level and pulls the wire low through an active-low enable. It handles all line timing so that the ROM and memory layers above it deal only in bits. Every action is timed from a falling edge made by the master. A long low pulse is taken as a bus reset: the block strobes the upper layers and answers on its own with a presence pulse. A short low pulse opens a time slot. If the upper layer has no bit waiting to send, the slot is a write slot and the block samples the level the master left on the wire. If the upper layer has a bit waiting, the slot is a read slot and the block either holds the wire low (for a 0) or leaves it released (for a 1).

Time is counted in microseconds. A divider driven by the `CLK_PER_US` parameter makes the microsecond tick, and the divider restarts on every line edge, so each window starts exactly on the master's edge. The upper layer loads `tx_en_i`/`tx_bit_i` before a slot and sees `tx_take_o` once the bit has been used. Received bits come out on `rx_valid_o`/`rx_bit_o` in the order they appear on the wire, least significant bit first.

Top module: `owire_bit_link`

## Requirements
- R1: After `rst_n` is deasserted, `pull_n_o` is 1 (line released) and `rx_valid_o`, `tx_take_o` and `bus_rst_o` are 0.
- R2: A low period on the line of at least `RST_US` (480) microseconds raises `bus_rst_o` for exactly one clock cycle. A low period of 300 microseconds or less raises it not at all.
- R3: When the line rises after a reset, the block waits `PD_WAIT_US` (30, inside the 15 to 60 window) and then drives `pull_n_o` low for `PD_LOW_US` (120, inside the 60 to 240 window). It releases the line whenever it is idle.
- R4: With `tx_en_i` low, a falling edge starts a write slot. The line is sampled `SAMPLE_US` (30) microseconds after the edge, which lies inside the 15 to 60 window. A low of 1 to 15 microseconds gives `rx_bit_o`=1, and a low of 60 microseconds or more gives `rx_bit_o`=0. Each slot gives exactly one `rx_valid_o` pulse.
- R5: With `tx_en_i` high at a falling edge, the slot is a read slot. `tx_take_o` pulses once, and no `rx_valid_o` is produced. For `tx_bit_i`=0, `pull_n_o` stays low from the edge until `RD_HOLD_US` (30) microseconds after it, so the line reads 0 at 10 microseconds and 1 at 45 microseconds. For `tx_bit_i`=1 the line is never driven.
- R6: A reset pulse that starts during a slot, including a read-0 hold, aborts the slot. It still yields one `bus_rst_o` pulse and a presence pulse, and the line is released when the reset is detected.
- R7: A new slot is recognised only after the line has returned high. Back-to-back slots separated by a few microseconds of recovery are each decoded, in bus order, least significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, `CLK_PER_US` cycles per microsecond |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronised level of the bus wire |
| pull_n_o | output | 1 | Open-drain enable, 0 pulls the wire low |
| tx_en_i | input | 1 | Upper layer has a bit to send in the next slot |
| tx_bit_i | input | 1 | Bit to send when `tx_en_i` is high |
| tx_take_o | output | 1 | One-cycle pulse: the pending transmit bit was used |
| rx_valid_o | output | 1 | One-cycle pulse: `rx_bit_o` holds a received bit |
| rx_bit_o | output | 1 | Received bit from the last write slot |
| bus_rst_o | output | 1 | One-cycle pulse on detection of a bus reset |

## Verification
The assertions assume that `line_i` is glitch-free and already synchronised. They also assume that the master keeps each slot-opening low for at least one microsecond, so the line is still low in the cycle after the edge has been registered. Both `tx_en_i` and `tx_bit_i` must be stable around a falling edge. The bench changes the master's pull-down and the transmit inputs only on falling clock edges. It holds every master low for two microseconds or more and leaves at least two microseconds of recovery between slots, which keeps the stimulus inside these assumptions.

// File: rtl/owl_pkg.sv
package owl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,    // released, waiting for a master edge
      ST_WSLOT,   // write slot, waiting for the sample point
      ST_RSLOT,   // read slot, holding or releasing the bit
      ST_WAITHI,  // slot or presence done, waiting for line high
      ST_RLOW,    // reset seen, waiting for the line to rise
      ST_PWAIT,   // gap before presence
      ST_PDRV     // presence low
   } owl_state_t;

   function automatic int unsigned owl_max(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/owl_tick.sv
module owl_tick #(
   parameter int unsigned CLK_PER_US = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int unsigned CW = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
   localparam bit          POW2 = ((CLK_PER_US & (CLK_PER_US - 1)) == 0);

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (clr) cnt <= '0;
            else          cnt <= cnt + CW'(1);
         end
         assign tick = (&cnt) && !clr;
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            cnt <= '0;
            else if (clr)                          cnt <= '0;
            else if (cnt == CW'(CLK_PER_US - 1))   cnt <= '0;
            else                                   cnt <= cnt + CW'(1);
         end
         assign tick = (cnt == CW'(CLK_PER_US - 1)) && !clr;
      end
   endgenerate

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick) else $error("tick not spaced"); // R4

endmodule

// File: rtl/owl_linemon.sv
module owl_linemon #(
   parameter int unsigned RST_US = 480
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic tick,
   output logic fall,
   output logic rise,
   output logic rst_hit
);
   localparam int unsigned LW = $clog2(RST_US + 1);

   logic          line_q;
   logic [LW-1:0] low_us;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b1;
         low_us <= '0;
      end else begin
         line_q <= line_i;
         if (line_i)
            low_us <= '0;
         else if (tick && (low_us != LW'(RST_US)))
            low_us <= low_us + LW'(1);
      end
   end

   assign fall    = line_q && !line_i;
   assign rise    = !line_q && line_i;
   assign rst_hit = !line_i && tick && (low_us == LW'(RST_US - 1));

endmodule

// File: rtl/owl_slot_fsm.sv
module owl_slot_fsm
   import owl_pkg::*;
#(
   parameter int unsigned SAMPLE_US  = 30,
   parameter int unsigned RD_HOLD_US = 30,
   parameter int unsigned PD_WAIT_US = 30,
   parameter int unsigned PD_LOW_US  = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic tick,
   input  logic fall,
   input  logic rst_hit,
   input  logic tx_en_i,
   input  logic tx_bit_i,
   output logic pull_n_o,
   output logic tx_take_o,
   output logic rx_valid_o,
   output logic rx_bit_o,
   output logic bus_rst_o
);
   localparam int unsigned MAXC = owl_max(owl_max(SAMPLE_US, RD_HOLD_US),
                                          owl_max(PD_WAIT_US, PD_LOW_US));
   localparam int unsigned UW   = $clog2(MAXC + 1);

   owl_state_t    st;
   logic [UW-1:0] us;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         us         <= '0;
         pull_n_o   <= 1'b1;
         tx_take_o  <= 1'b0;
         rx_valid_o <= 1'b0;
         rx_bit_o   <= 1'b0;
         bus_rst_o  <= 1'b0;
      end else begin
         tx_take_o  <= 1'b0;
         rx_valid_o <= 1'b0;
         bus_rst_o  <= 1'b0;
         if (rst_hit) begin
            bus_rst_o <= 1'b1;
            pull_n_o  <= 1'b1;
            st        <= ST_RLOW;
         end else begin
            unique case (st)
               ST_IDLE: if (fall) begin
                  us <= '0;
                  if (tx_en_i) begin
                     tx_take_o <= 1'b1;
                     pull_n_o  <= tx_bit_i;
                     st        <= ST_RSLOT;
                  end else begin
                     st <= ST_WSLOT;
                  end
               end
               ST_WSLOT: if (tick) begin
                  if (us == UW'(SAMPLE_US - 1)) begin
                     rx_valid_o <= 1'b1;
                     rx_bit_o   <= line_i;
                     st         <= ST_WAITHI;
                  end else us <= us + UW'(1);
               end
               ST_RSLOT: if (tick) begin
                  if (us == UW'(RD_HOLD_US - 1)) begin
                     pull_n_o <= 1'b1;
                     st       <= ST_WAITHI;
                  end else us <= us + UW'(1);
               end
               ST_WAITHI: if (line_i) st <= ST_IDLE;
               ST_RLOW: if (line_i) begin
                  us <= '0;
                  st <= ST_PWAIT;
               end
               ST_PWAIT: if (tick) begin
                  if (us == UW'(PD_WAIT_US - 1)) begin
                     us       <= '0;
                     pull_n_o <= 1'b0;
                     st       <= ST_PDRV;
                  end else us <= us + UW'(1);
               end
               ST_PDRV: if (tick) begin
                  if (us == UW'(PD_LOW_US - 1)) begin
                     pull_n_o <= 1'b1;
                     st       <= ST_WAITHI;
                  end else us <= us + UW'(1);
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_o |=> !bus_rst_o) else $error("reset strobe too long"); // R2
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> pull_n_o) else $error("driving while idle"); // R3
   AST_RX_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid_o && tx_take_o)) else $error("read and write in one slot"); // R5
   AST_TAKE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take_o |-> !line_i) else $error("bit taken without a low"); // R5
   AST_RELEASE_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_o |-> pull_n_o) else $error("line held at reset"); // R6

endmodule

// File: rtl/owire_bit_link.sv
module owire_bit_link #(
   parameter int unsigned CLK_PER_US = 125,
   parameter int unsigned RST_US     = 480,
   parameter int unsigned SAMPLE_US  = 30,
   parameter int unsigned RD_HOLD_US = 30,
   parameter int unsigned PD_WAIT_US = 30,
   parameter int unsigned PD_LOW_US  = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic pull_n_o,
   input  logic tx_en_i,
   input  logic tx_bit_i,
   output logic tx_take_o,
   output logic rx_valid_o,
   output logic rx_bit_o,
   output logic bus_rst_o
);
   generate
      if (CLK_PER_US < 2) begin : g_bad_clk
         $error("CLK_PER_US must be at least 2");
      end
      if (SAMPLE_US < 15 || SAMPLE_US > 60) begin : g_bad_sample
         $error("SAMPLE_US outside the 15..60 window");
      end
      if (RD_HOLD_US < 15 || RD_HOLD_US > 59) begin : g_bad_hold
         $error("RD_HOLD_US outside the 15..59 window");
      end
      if (PD_WAIT_US < 15 || PD_WAIT_US > 60) begin : g_bad_pdw
         $error("PD_WAIT_US outside the 15..60 window");
      end
      if (PD_LOW_US < 60 || PD_LOW_US > 240) begin : g_bad_pdl
         $error("PD_LOW_US outside the 60..240 window");
      end
      if (RST_US <= PD_LOW_US) begin : g_bad_rst
         $error("RST_US must exceed PD_LOW_US");
      end
   endgenerate

   logic tick, fall, rise, rst_hit;

   owl_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fall | rise),
      .tick  (tick)
   );

   owl_linemon #(.RST_US(RST_US)) u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line_i),
      .tick    (tick),
      .fall    (fall),
      .rise    (rise),
      .rst_hit (rst_hit)
   );

   owl_slot_fsm #(
      .SAMPLE_US  (SAMPLE_US),
      .RD_HOLD_US (RD_HOLD_US),
      .PD_WAIT_US (PD_WAIT_US),
      .PD_LOW_US  (PD_LOW_US)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_i),
      .tick       (tick),
      .fall       (fall),
      .rst_hit    (rst_hit),
      .tx_en_i    (tx_en_i),
      .tx_bit_i   (tx_bit_i),
      .pull_n_o   (pull_n_o),
      .tx_take_o  (tx_take_o),
      .rx_valid_o (rx_valid_o),
      .rx_bit_o   (rx_bit_o),
      .bus_rst_o  (bus_rst_o)
   );

endmodule

// File: tb/tb_owire_bit_link.sv
module tb_owire_bit_link;
   localparam int C = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_low = 1'b0;
   logic tx_en = 1'b0;
   logic tx_bit = 1'b0;
   logic pull_n_o, tx_take_o, rx_valid_o, rx_bit_o, bus_rst_o;
   logic line;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int rx_cnt = 0, tk_cnt = 0, rs_cnt = 0, rx_at = 0;
   logic rx_last = 1'b0;

   always #4 clk = ~clk;

   assign line = !master_low && pull_n_o;

   owire_bit_link #(.CLK_PER_US(C)) dut (
      .clk(clk), .rst_n(rst_n), .line_i(line), .pull_n_o(pull_n_o),
      .tx_en_i(tx_en), .tx_bit_i(tx_bit), .tx_take_o(tx_take_o),
      .rx_valid_o(rx_valid_o), .rx_bit_o(rx_bit_o), .bus_rst_o(bus_rst_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rx_valid_o) begin rx_cnt++; rx_last = rx_bit_o; rx_at = cyc; end
      if (tx_take_o) tk_cnt++;
      if (bus_rst_o) rs_cnt++;
   end

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_rng(string tag, int act, int lo, int hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic wait_us(int n);
      repeat (n * C) @(negedge clk);
   endtask

   task automatic presence_check(string tag);
      int gap = 0;
      int len = 0;
      while (pull_n_o && gap < 100 * C) begin @(negedge clk); gap++; end
      chk_rng({tag, " presence gap"}, gap, 15 * C, 60 * C);
      while (!pull_n_o && len < 300 * C) begin @(negedge clk); len++; end
      chk_rng({tag, " presence length"}, len, 60 * C, 240 * C);
      wait_us(5);
   endtask

   // R2 R3: full reset pulse and presence answer
   task automatic t_reset();
      int rs0 = rs_cnt;
      master_low = 1'b1;
      wait_us(500);
      master_low = 1'b0;
      chk("R2 one strobe per reset", rs_cnt - rs0, 1);
      presence_check("R3");
   endtask

   // R4: one write slot
   task automatic t_write(logic b, string tag);
      int rx0 = rx_cnt;
      int t0;
      master_low = 1'b1;
      t0 = cyc;
      wait_us(b ? 3 : 65);
      master_low = 1'b0;
      wait_us(b ? 67 : 5);
      chk({tag, " one rx per slot"}, rx_cnt - rx0, 1);
      chk({tag, " rx bit"}, int'(rx_last), int'(b));
      chk_rng({tag, " sample time"}, rx_at - t0, 15 * C, 60 * C);
      wait_us(2);
   endtask

   // R5: one read slot
   task automatic t_read(logic b, string tag);
      int rx0 = rx_cnt;
      int tk0 = tk_cnt;
      tx_en = 1'b1;
      tx_bit = b;
      @(negedge clk);
      master_low = 1'b1;
      wait_us(2);
      master_low = 1'b0;
      wait_us(8);
      chk({tag, " line at 10us"}, int'(line), int'(b));
      wait_us(35);
      chk({tag, " line at 45us"}, int'(line), 1);
      wait_us(25);
      tx_en = 1'b0;
      chk({tag, " one take"}, tk_cnt - tk0, 1);
      chk({tag, " no rx in read slot"}, rx_cnt - rx0, 0);
      wait_us(3);
   endtask

   // R7: eight back-to-back write slots, LSB first
   task automatic t_byte(logic [7:0] v);
      logic [7:0] got = '0;
      for (int i = 0; i < 8; i++) begin
         master_low = 1'b1;
         wait_us(v[i] ? 3 : 65);
         master_low = 1'b0;
         wait_us(v[i] ? 67 : 5);
         got[i] = rx_last;
         wait_us(2);
      end
      chk("R7 byte assembled LSB first", int'(got), int'(v));
   endtask

   // R2: a 300us low is no reset
   task automatic t_short_low();
      int rs0 = rs_cnt;
      master_low = 1'b1;
      wait_us(300);
      master_low = 1'b0;
      wait_us(10);
      chk("R2 no strobe on 300us low", rs_cnt - rs0, 0);
   endtask

   // R6: reset starting inside a read-0 slot
   task automatic t_abort();
      int rs0 = rs_cnt;
      int tk0 = tk_cnt;
      tx_en = 1'b1;
      tx_bit = 1'b0;
      @(negedge clk);
      master_low = 1'b1;
      wait_us(1);
      tx_en = 1'b0;
      wait_us(499);
      master_low = 1'b0;
      chk("R6 strobe after aborted slot", rs_cnt - rs0, 1);
      chk("R6 single take in aborted slot", tk_cnt - tk0, 1);
      presence_check("R6");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 released after reset", int'(pull_n_o), 1);
      chk("R1 no rx strobe", int'(rx_valid_o), 0);
      chk("R1 no reset strobe", int'(bus_rst_o), 0);
      rst_n = 1'b1;
      wait_us(5);
      chk("R1 still released", int'(pull_n_o), 1);
      t_reset();
      t_write(1'b1, "R4 write-1");
      t_write(1'b0, "R4 write-0");
      t_read(1'b0, "R5 read-0");
      t_read(1'b1, "R5 read-1");
      t_byte(8'hA5);
      t_short_low();
      t_abort();
      t_write(1'b0, "R4 after abort");
      t_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule